// File: doc/BRIEF.md
# Three-Phase Gate Command Conditioner

This block sits between a PWM generator and the gate drivers of a three-leg inverter bridge. For each leg it takes a high-side and a low-side switch command and produces the two gate-enable outputs that actually reach the drivers. Every command, and the global run enable, first goes through a digital glitch filter, so that only levels held for a programmable number of clock cycles are accepted.

After filtering, each leg is guarded on its own. The two switches of a leg are never on together. If both are requested at once, the leg parks with both switches off. A switch may only turn on after its partner has been off for a programmable dead time. A low global enable, a shutdown request from a separate fault block, or a supply undervoltage flag drives the affected outputs low. A high-side switch that was cut by its own supply undervoltage stays off until its command has been released and applied again. Low-side switches simply follow their command level again once the low-side supply recovers. All durations are parameters counted in clock cycles, and command polarity is chosen by a parameter.

Top module: `tri_leg_gate_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all six gate outputs are low. Every filter starts at its inactive level, and the dead-time counters start at zero.
- R2: A command or enable change reaches the guard logic only after it has been seen at the same level on FILT_CYC consecutive clock edges. A gate output therefore responds FILT_CYC+1 edges after an accepted change. A pulse, on or off, that lasts fewer than FILT_CYC cycles has no effect on the outputs.
- R3: With ACTIVE_LOW=1 (the default), a command input at 0 requests its switch on and a 1 requests it off. With ACTIVE_LOW=0 the meaning is reversed. The enable input is always active-high.
- R4: The high-side and low-side outputs of one leg are never high in the same cycle. When both filtered requests of a leg are active, both of its outputs are low on the next edge.
- R5: When one output of a leg falls, the complementary output of that leg may rise DEAD_CYC+1 edges later at the earliest. At that point both outputs have been low for at least DEAD_CYC cycles.
- R6: When the filtered enable is low, all six outputs are low on the next edge.
- R7: When shutdown_req is high at a clock edge, all six outputs are low after that edge, whatever the commands are.
- R8: When ls_uv is high, all low-side outputs go low on the next edge. Once ls_uv falls, each low-side output again follows its filtered command level, with R4 and R5 still applying.
- R9: When hs_uv[i] is high, hs_gate[i] goes low on the next edge. After hs_uv[i] falls, hs_gate[i] stays low until its filtered command has been seen inactive and then active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | LEGS | High-side switch commands, polarity per ACTIVE_LOW |
| lo_cmd | input | LEGS | Low-side switch commands, polarity per ACTIVE_LOW |
| run_en | input | 1 | Global enable, active-high, filtered |
| shutdown_req | input | 1 | Fault shutdown request, active-high, unfiltered |
| hs_uv | input | LEGS | Per-leg high-side supply undervoltage flags |
| ls_uv | input | 1 | Low-side supply undervoltage flag |
| hs_gate | output | LEGS | High-side gate enables |
| ls_gate | output | LEGS | Low-side gate enables |

## Verification
The assertions assume that every input is synchronous to clk and that the undervoltage and shutdown flags are already clean digital levels, since only the commands and the enable are filtered. The stimulus changes all inputs one time unit after a rising edge. It holds the commands for random spans that fall both below and above the filter length, which produces accepted changes, rejected glitches, and simultaneous same-leg requests. Enable drops, shutdown pulses and undervoltage pulses are sparse, so the dead-time and re-arm paths are reached many times between them.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } gate_pair_t;

  function automatic logic to_active(input logic raw, input bit act_low);
    return act_low ? ~raw : raw;
  endfunction
endpackage

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int unsigned CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = '0;
    lvl_d = lvl_q;
    if (din != lvl_q) begin
      if (cnt_q == LAST) lvl_d = din;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign dout = lvl_q;

  assert_filt_rise_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(din));
  assert_filt_fall_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl_q) |-> !$past(din));
endmodule

// File: rtl/leg_guard.sv
module leg_guard
  import gate_guard_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hreq,
  input  logic lreq,
  input  logic run_ok,
  input  logic hs_uv,
  input  logic ls_uv,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int unsigned DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DMAX = DW'(DEAD_CYC);

  gate_pair_t    g_q, g_d;
  logic [DW-1:0] off_q, off_d;
  logic          arm_q, arm_d;
  logic          gap_done, hs_want, ls_want;

  assign gap_done = (off_q == DMAX);

  always_comb begin
    hs_want = hreq & ~lreq & ~hs_uv & arm_q;
    ls_want = lreq & ~hreq & ~ls_uv;
    g_d.hs  = run_ok & hs_want & (g_q.hs | (~g_q.ls & gap_done));
    g_d.ls  = run_ok & ls_want & (g_q.ls | (~g_q.hs & gap_done));

    if (g_q.hs | g_q.ls)  off_d = '0;
    else if (!gap_done)   off_d = off_q + 1'b1;
    else                  off_d = off_q;

    if (hs_uv)      arm_d = 1'b0;
    else if (!hreq) arm_d = 1'b1;
    else            arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q   <= '0;
      off_q <= '0;
      arm_q <= 1'b1;
    end else begin
      g_q   <= g_d;
      off_q <= off_d;
      arm_q <= arm_d;
    end
  end

  assign hs_gate = g_q.hs;
  assign ls_gate = g_q.ls;

  // independent count of cycles with both gates low, for the dead-time check
  logic [DW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run_q <= '0;
    else if (hs_gate | ls_gate) low_run_q <= '0;
    else if (low_run_q != DMAX) low_run_q <= low_run_q + 1'b1;
  end

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));
  assert_both_req_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq && lreq) |=> (!hs_gate && !ls_gate));
  assert_hs_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> ($past(low_run_q) == DMAX));
  assert_ls_dead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> ($past(low_run_q) == DMAX));
  assert_run_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> (!hs_gate && !ls_gate));
  assert_ls_uv_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ls_uv |=> !ls_gate);
  assert_hs_uv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hs_uv |=> !hs_gate);
endmodule

// File: rtl/tri_leg_gate_guard.sv
module tri_leg_gate_guard
  import gate_guard_pkg::*;
#(
  parameter int unsigned LEGS       = 3,
  parameter int unsigned FILT_CYC   = 6,
  parameter int unsigned DEAD_CYC   = 8,
  parameter bit          ACTIVE_LOW = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LEGS-1:0] hi_cmd,
  input  logic [LEGS-1:0] lo_cmd,
  input  logic            run_en,
  input  logic            shutdown_req,
  input  logic [LEGS-1:0] hs_uv,
  input  logic            ls_uv,
  output logic [LEGS-1:0] hs_gate,
  output logic [LEGS-1:0] ls_gate
);
  logic [LEGS-1:0] hreq_f, lreq_f;
  logic            en_f, run_ok;

  glitch_filter #(.CYC(FILT_CYC)) u_en_filt (
    .clk(clk), .rst_n(rst_n), .din(run_en), .dout(en_f)
  );

  assign run_ok = en_f & ~shutdown_req;

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    glitch_filter #(.CYC(FILT_CYC)) u_hi_filt (
      .clk(clk), .rst_n(rst_n),
      .din(to_active(hi_cmd[i], ACTIVE_LOW)), .dout(hreq_f[i])
    );
    glitch_filter #(.CYC(FILT_CYC)) u_lo_filt (
      .clk(clk), .rst_n(rst_n),
      .din(to_active(lo_cmd[i], ACTIVE_LOW)), .dout(lreq_f[i])
    );
    leg_guard #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .hreq(hreq_f[i]), .lreq(lreq_f[i]), .run_ok(run_ok),
      .hs_uv(hs_uv[i]), .ls_uv(ls_uv),
      .hs_gate(hs_gate[i]), .ls_gate(ls_gate[i])
    );
  end

  assert_shutdown_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> (hs_gate == '0 && ls_gate == '0));
  assert_first_cycle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (hs_gate == '0 && ls_gate == '0));
endmodule

// File: tb/tb_tri_leg_gate_guard.sv
module tb_tri_leg_gate_guard;
  localparam int CLK_PERIOD = 10;
  localparam int L = 3;
  localparam int F = 6;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [L-1:0] hi_cmd, lo_cmd, hs_uv, hs_gate, ls_gate;
  logic run_en, shutdown_req, ls_uv;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tri_leg_gate_guard #(.LEGS(L), .FILT_CYC(F), .DEAD_CYC(D), .ACTIVE_LOW(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .run_en(run_en), .shutdown_req(shutdown_req), .hs_uv(hs_uv), .ls_uv(ls_uv),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model from the requirements ----------------
  logic [L-1:0] s_hi, s_lo, s_huv;
  logic s_en, s_sd, s_luv, s_rst;
  bit fv [2*L];  int fc [2*L];
  bit ef;        int ec;
  bit m_hs [L];  bit m_ls [L];  int m_off [L];  bit m_arm [L];

  always @(posedge clk) begin
    s_hi <= hi_cmd; s_lo <= lo_cmd; s_huv <= hs_uv;
    s_en <= run_en; s_sd <= shutdown_req; s_luv <= ls_uv; s_rst <= rst_n;
  end

  task automatic filt_step(inout bit v, inout int c, input bit a);
    if (a != v) begin
      if (c == F-1) begin v = a; c = 0; end
      else c++;
    end else c = 0;
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2*L; k++) begin fv[k] = 0; fc[k] = 0; end
    ef = 0; ec = 0;
    for (int k = 0; k < L; k++) begin m_hs[k] = 0; m_ls[k] = 0; m_off[k] = 0; m_arm[k] = 1; end
  endtask

  task automatic model_step();
    bit run, hr, lr, nh, nl, gap;
    run = ef && !s_sd;
    for (int k = 0; k < L; k++) begin
      hr = fv[k]; lr = fv[L+k]; gap = (m_off[k] == D);
      nh = run && hr && !lr && !s_huv[k] && m_arm[k] && (m_hs[k] || (!m_ls[k] && gap));
      nl = run && lr && !hr && !s_luv && (m_ls[k] || (!m_hs[k] && gap));
      if (m_hs[k] || m_ls[k]) m_off[k] = 0;
      else if (!gap) m_off[k]++;
      if (s_huv[k]) m_arm[k] = 0;
      else if (!hr) m_arm[k] = 1;
      m_hs[k] = nh; m_ls[k] = nl;
    end
    filt_step(ef, ec, s_en);
    for (int k = 0; k < L; k++) begin
      filt_step(fv[k], fc[k], !s_hi[k]);
      filt_step(fv[L+k], fc[L+k], !s_lo[k]);
    end
  endtask

  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on) begin
      logic [L-1:0] eh, el;
      if (!s_rst) model_reset(); else model_step();
      for (int k = 0; k < L; k++) begin eh[k] = m_hs[k]; el[k] = m_ls[k]; end
      checks++;
      if (hs_gate !== eh || ls_gate !== el) begin
        failures++;
        $display("FAIL model R2/R4/R5/R6/R7/R8/R9 t=%0t hs=%b ls=%b exp hs=%b ls=%b",
                 $time, hs_gate, ls_gate, eh, el);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // active-low commands: 0 = on
  task automatic set_hi(input int k, input bit on); hi_cmd[k] = !on; endtask
  task automatic set_lo(input int k, input bit on); lo_cmd[k] = !on; endtask

  // ---------------- stimulus ----------------
  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst_n = 0; hi_cmd = '1; lo_cmd = '1; run_en = 0; shutdown_req = 0;
    hs_uv = '0; ls_uv = 0;
    model_reset();
    model_on = 1;
    step(3);
    chk("R1 reset hs", hs_gate, '0);
    chk("R1 reset ls", ls_gate, '0);
    @(negedge clk); rst_n = 1;
    step(1);
    chk("R1 first cycle hs", hs_gate, '0);
    run_en = 1;
    step(F + D + 4);

    // R3/R2: active-low command on leg 0 high side, exact latency
    set_hi(0, 1);
    step(F);
    chk("R2 latency not yet", hs_gate, 3'b000);
    step(1);
    chk("R3 R2 hs on at F+1", hs_gate, 3'b001);

    // R5: swap leg 0 from high to low side
    set_hi(0, 0); set_lo(0, 1);
    step(F + 1);
    chk("R5 hs off", hs_gate, 3'b000);
    step(D);
    chk("R5 ls still off in gap", ls_gate, 3'b000);
    step(1);
    chk("R5 ls on after DEAD_CYC+1", ls_gate, 3'b001);

    // R2: short off glitch on the active low-side command is rejected
    set_lo(0, 0); step(F - 1); set_lo(0, 1);
    step(2 * F);
    chk("R2 off glitch ignored", ls_gate, 3'b001);
    // R2: short on glitch on an idle command is rejected
    set_hi(2, 1); step(F - 1); set_hi(2, 0);
    step(2 * F);
    chk("R2 on glitch ignored", hs_gate, 3'b000);

    // R4: both requests on leg 1 from idle
    set_hi(1, 1); set_lo(1, 1);
    step(F + D + 4);
    chk("R4 both requested hs", hs_gate, 3'b000);
    chk("R4 both requested ls", ls_gate, 3'b001);
    set_lo(1, 0);
    step(F + 1);
    chk("R4 resume after release", hs_gate, 3'b010);

    // R7: shutdown
    shutdown_req = 1; step(1);
    chk("R7 shutdown hs", hs_gate, 3'b000);
    chk("R7 shutdown ls", ls_gate, 3'b000);
    shutdown_req = 0; step(D + 2);
    chk("R7 release recovers", hs_gate | ls_gate, 3'b011);

    // R8: low-side undervoltage on leg 0 (ls active)
    ls_uv = 1; step(1);
    chk("R8 ls uv off", ls_gate, 3'b000);
    step(D + 2); ls_uv = 0; step(1);
    chk("R8 ls follows level", ls_gate, 3'b001);

    // R9: high-side undervoltage on leg 1 (hs active)
    hs_uv[1] = 1; step(1);
    chk("R9 hs uv off", hs_gate, 3'b000);
    step(D + 2); hs_uv[1] = 0; step(F + D);
    chk("R9 stays off without new edge", hs_gate, 3'b000);
    set_hi(1, 0); step(F + 2); set_hi(1, 1); step(F + 1);
    chk("R9 fresh edge re-arms", hs_gate, 3'b010);

    // R6: enable low
    run_en = 0; step(F);
    chk("R6 enable filtered, still on", hs_gate, 3'b010);
    step(1);
    chk("R6 enable low hs", hs_gate, 3'b000);
    chk("R6 enable low ls", ls_gate, 3'b000);
    run_en = 1; step(F + 2);

    // constrained random phase
    for (int cyc = 0; cyc < 6000; cyc++) begin
      for (int k = 0; k < L; k++) begin
        if ($urandom_range(0, 9) == 0) hi_cmd[k] = ~hi_cmd[k];
        if ($urandom_range(0, 9) == 0) lo_cmd[k] = ~lo_cmd[k];
        if ($urandom_range(0, 299) == 0) hs_uv[k] = ~hs_uv[k];
      end
      if ($urandom_range(0, 399) == 0) run_en = ~run_en;
      if ($urandom_range(0, 399) == 0) ls_uv = ~ls_uv;
      shutdown_req = ($urandom_range(0, 249) == 0);
      step(1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule